// File: doc/BRIEF.md
# Memory-Mapped Multiplexed Character Display

This peripheral sits on a processor's write bus and shows text on a row of multiplexed seven-segment digits. The block watches every write. A write whose address equals the reserved output address is taken as a character code. The code is translated through a glyph table into a segment pattern. That pattern is stored in the digit register chosen by a write pointer, and the pointer then moves on to the next digit.

A prescaler and a scan counter run freely. They enable one digit at a time in a fixed rotation and drive that digit's stored pattern onto shared segment lines. Each digit stays lit for 2^PRESCALE_LOG2 clocks. Software prints by writing codes one after another, and the text fills the digits from left to right before wrapping.

Top module: `char_disp_top`

## Requirements
- R1: After reset every digit register holds the blank pattern 0x00, the write pointer is 0, and the scan selects digit 0 (dig_en_o = 4'b0001).
- R2: A character is captured only on a clock where wr_en_i is high and wr_addr_i equals 16'hFFFF. Any other write leaves every digit register and the write pointer unchanged.
- R3: Codes 0 to 25 (letters A to Z) store the following patterns, in code order, with bit 0 = segment a through bit 6 = segment g: 77 7C 39 5E 79 71 3D 76 30 1E 75 38 37 54 5C 73 67 50 6D 78 3E 1C 2A 49 6E 5B (hex).
- R4: Codes 26 to 35 (digits 0 to 9) store the following patterns, in code order: 3F 06 5B 4F 66 6D 7D 07 7F 6F (hex).
- R5: A code of 36 or above (any of the 16 data bits) stores the blank pattern 0x00.
- R6: Captured characters go to digits 0, 1, 2, 3 in turn. The pointer advances by one on each capture and wraps from 3 to 0.
- R7: dig_en_o is one-hot at all times, with bit k set while digit k is scanned. The scan visits digits in the order 0, 1, 2, 3, 0, and so on.
- R8: Each digit stays enabled for exactly 2^PRESCALE_LOG2 consecutive clocks.
- R9: seg_o (active high, same bit order as R3) equals the stored pattern of the digit that is currently enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Processor write strobe |
| wr_addr_i | input | 16 | Write address |
| wr_data_i | input | 16 | Write data (character code) |
| seg_o | output | 7 | Segment lines of the enabled digit, active high |
| dig_en_o | output | 4 | One-hot digit enables |

## Verification
A wrong write pointer puts the next character on the wrong digit. This shows at the ports within one scan rotation, which is four dwell periods. A corrupt digit register or glyph entry gives a wrong seg_o while that digit is enabled. A faulty prescaler or scan counter shows up as a dwell length other than 2^N, or as a non-one-hot enable, on the first digit change. The bench sweeps every code from 0 to 39 plus large codes, and reads each stored digit back through the scan. This gives both a glyph check and a pointer check for every write.

// File: rtl/char_disp_pkg.sv
package char_disp_pkg;
  localparam int unsigned SEG_W       = 7;
  localparam int unsigned GLYPH_COUNT = 36;
  typedef logic [SEG_W-1:0] seg_t;
  localparam seg_t SEG_BLANK = '0;
endpackage

// File: rtl/char_glyph_rom.sv
module char_glyph_rom
  import char_disp_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] code_i,
  output seg_t              seg_o
);
  logic in_range;
  assign in_range = code_i < DATA_W'(GLYPH_COUNT);

  always_comb begin
    seg_o = SEG_BLANK;
    if (in_range) begin
      case (code_i[5:0])
        6'd0:  seg_o = 7'h77;
        6'd1:  seg_o = 7'h7C;
        6'd2:  seg_o = 7'h39;
        6'd3:  seg_o = 7'h5E;
        6'd4:  seg_o = 7'h79;
        6'd5:  seg_o = 7'h71;
        6'd6:  seg_o = 7'h3D;
        6'd7:  seg_o = 7'h76;
        6'd8:  seg_o = 7'h30;
        6'd9:  seg_o = 7'h1E;
        6'd10: seg_o = 7'h75;
        6'd11: seg_o = 7'h38;
        6'd12: seg_o = 7'h37;
        6'd13: seg_o = 7'h54;
        6'd14: seg_o = 7'h5C;
        6'd15: seg_o = 7'h73;
        6'd16: seg_o = 7'h67;
        6'd17: seg_o = 7'h50;
        6'd18: seg_o = 7'h6D;
        6'd19: seg_o = 7'h78;
        6'd20: seg_o = 7'h3E;
        6'd21: seg_o = 7'h1C;
        6'd22: seg_o = 7'h2A;
        6'd23: seg_o = 7'h49;
        6'd24: seg_o = 7'h6E;
        6'd25: seg_o = 7'h5B;
        6'd26: seg_o = 7'h3F;
        6'd27: seg_o = 7'h06;
        6'd28: seg_o = 7'h5B;
        6'd29: seg_o = 7'h4F;
        6'd30: seg_o = 7'h66;
        6'd31: seg_o = 7'h6D;
        6'd32: seg_o = 7'h7D;
        6'd33: seg_o = 7'h07;
        6'd34: seg_o = 7'h7F;
        6'd35: seg_o = 7'h6F;
        default: seg_o = SEG_BLANK;
      endcase
    end
  end

  // R5: out-of-range codes never light a segment
  always_comb begin
    if (!in_range) a_r5_blank_oor: assert (seg_o == SEG_BLANK);
  end
endmodule

// File: rtl/char_digit_bank.sv
module char_digit_bank
  import char_disp_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  localparam int unsigned PTR_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_hit_i,
  input  seg_t                        wr_seg_i,
  output logic [NUM_DIGITS*SEG_W-1:0] digits_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_DIGITS - 1);

  logic [PTR_W-1:0] wptr_q;
  seg_t             dig_q [NUM_DIGITS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wptr_q <= '0;
    else if (wr_hit_i) wptr_q <= (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dig
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       dig_q[k] <= SEG_BLANK;
      else if (wr_hit_i && wptr_q == PTR_W'(k))          dig_q[k] <= wr_seg_i;
    end
    assign digits_o[k*SEG_W +: SEG_W] = dig_q[k];
  end

  // R2: missed writes leave the pointer alone
  a_r2_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit_i |=> $stable(wptr_q));
  // R6: each capture moves the pointer by one with wrap
  a_r6_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit_i |=> wptr_q == (($past(wptr_q) == PTR_LAST) ? '0 : $past(wptr_q) + 1'b1));
  // R2: missed writes leave digit 0 alone
  a_r2_dig0_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit_i |=> $stable(dig_q[0]));
endmodule

// File: rtl/char_scan.sv
module char_scan #(
  parameter int unsigned NUM_DIGITS    = 4,
  parameter int unsigned PRESCALE_LOG2 = 10,
  localparam int unsigned SCAN_W       = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic [SCAN_W-1:0]     scan_o,
  output logic [NUM_DIGITS-1:0] dig_en_o
);
  localparam logic [SCAN_W-1:0] SCAN_LAST = SCAN_W'(NUM_DIGITS - 1);

  logic [PRESCALE_LOG2-1:0] pre_q;
  logic [SCAN_W-1:0]        scan_q;
  logic                     tick;

  assign tick = &pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      scan_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (tick) scan_q <= (scan_q == SCAN_LAST) ? '0 : scan_q + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dec
    assign dig_en_o[k] = (scan_q == SCAN_W'(k));
  end
  assign scan_o = scan_q;

  // R7: exactly one digit enabled
  a_r7_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(dig_en_o) == 1);
  // R8: scan holds between prescaler wraps
  a_r8_dwell_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(scan_q));
  // R7: scan advances in order on a wrap
  a_r7_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> scan_q == (($past(scan_q) == SCAN_LAST) ? '0 : $past(scan_q) + 1'b1));
endmodule

// File: rtl/char_disp_top.sv
module char_disp_top
  import char_disp_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned NUM_DIGITS    = 4,
  parameter int unsigned PRESCALE_LOG2 = 10,
  parameter logic [ADDR_W-1:0] OUT_ADDR = '1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [SEG_W-1:0]      seg_o,
  output logic [NUM_DIGITS-1:0] dig_en_o
);
  localparam int unsigned SCAN_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

  logic                        wr_hit;
  seg_t                        glyph;
  logic [NUM_DIGITS*SEG_W-1:0] digits;
  logic [SCAN_W-1:0]           scan;

  assign wr_hit = wr_en_i && (wr_addr_i == OUT_ADDR);

  char_glyph_rom #(.DATA_W(DATA_W)) u_rom (
    .code_i (wr_data_i),
    .seg_o  (glyph)
  );

  char_digit_bank #(.NUM_DIGITS(NUM_DIGITS)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hit_i (wr_hit),
    .wr_seg_i (glyph),
    .digits_o (digits)
  );

  char_scan #(.NUM_DIGITS(NUM_DIGITS), .PRESCALE_LOG2(PRESCALE_LOG2)) u_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scan_o   (scan),
    .dig_en_o (dig_en_o)
  );

  assign seg_o = digits[scan*SEG_W +: SEG_W];

  // R9: lit segments change only with the scan or a capture
  a_r9_seg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_hit && $stable(dig_en_o)) |=> $stable(seg_o) || $changed(dig_en_o));
endmodule

// File: tb/tb_char_disp_top.sv
module tb_char_disp_top;
  localparam int N = 2;
  localparam int DWELL = 1 << N;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [15:0] addr = 0, data = 0;
  logic [6:0] seg;
  logic [3:0] den;
  int checks = 0, fails = 0;
  logic [6:0] model [4];
  int wp = 0;

  always #2.5 clk = ~clk;

  char_disp_top #(.PRESCALE_LOG2(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(addr),
    .wr_data_i(data), .seg_o(seg), .dig_en_o(den));

  function automatic logic [6:0] glyph(int c);
    logic [6:0] l [26] = '{7'h77,7'h7C,7'h39,7'h5E,7'h79,7'h71,7'h3D,7'h76,7'h30,
      7'h1E,7'h75,7'h38,7'h37,7'h54,7'h5C,7'h73,7'h67,7'h50,7'h6D,7'h78,7'h3E,
      7'h1C,7'h2A,7'h49,7'h6E,7'h5B};
    logic [6:0] d [10] = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,7'h7F,7'h6F};
    if (c < 26) return l[c];
    if (c < 36) return d[c-26];
    return 7'h00;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic en, logic [15:0] a, logic [15:0] d);
    @(negedge clk); wr_en = en; addr = a; data = d;
    @(negedge clk); wr_en = 0;
    if (en && a == 16'hFFFF) begin
      model[wp] = glyph(int'(d));
      wp = (wp + 1) % 4;
    end
  endtask

  task automatic see(int k, string req);
    int n = 0;
    while (den != 4'(1 << k) && n < 40) begin @(negedge clk); n++; end
    chk(req, int'(seg), int'(model[k]));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) model[k] = 7'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset scan", int'(den), 1);
    for (int k = 0; k < 4; k++) see(k, "R1 reset blank");

    // R7 / R8: order and dwell over two rotations
    begin
      int cur, len;
      while (den != 4'b0001) @(negedge clk);
      while (den == 4'b0001) @(negedge clk);
      for (int s = 0; s < 8; s++) begin
        cur = int'(den); len = 0;
        chk("R7 onehot", $countones(den), 1);
        chk("R7 order", cur, 1 << ((s + 1) % 4));
        while (int'(den) == cur && len < 100) begin @(negedge clk); len++; end
        chk("R8 dwell", len, DWELL);
      end
    end

    // R3 R4 R5 R6 R9: sweep codes, each read back on its digit
    for (int c = 0; c < 40; c++) begin
      int tgt = wp;
      wr(1, 16'hFFFF, 16'(c));
      see(tgt, c < 26 ? "R3 letter" : (c < 36 ? "R4 digit" : "R5 blank"));
    end
    for (int k = 0; k < 3; k++) begin
      logic [15:0] big [3] = '{16'h0100, 16'h8000, 16'hFFFF};
      int tgt = wp;
      wr(1, 16'hFFFF, 16'h0000);
      wr(1, 16'hFFFF, big[k]);
      see(tgt, "R6 pointer"); see((tgt + 1) % 4, "R5 large code");
    end

    // R2: ignored writes
    while (wp != 0) wr(1, 16'hFFFF, 16'd27);
    for (int k = 0; k < 4; k++) wr(1, 16'hFFFF, 16'(26 + k));
    wr(1, 16'hFFFE, 16'd0);
    wr(1, 16'h7FFF, 16'd1);
    wr(0, 16'hFFFF, 16'd2);
    for (int k = 0; k < 4; k++) see(k, "R2 digits unchanged");
    wr(1, 16'hFFFF, 16'd7);
    see(0, "R2 pointer unchanged");
    see(1, "R6 neighbour intact");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule